// File: doc/BRIEF.md
# I2C Transaction Sequencer

This block runs a whole short I2C transaction on its own once software has loaded the transmit bytes and written a single control word. The word selects a write phase, a read phase or both, the 7-bit or 10-bit target address, the byte count of each phase (1 to 8), and whether the two phases are joined by a repeated START. The sequencer issues START, address, data, repeated START and STOP commands to a byte-level I2C master through a one-outstanding command/response handshake. It never drives the bus wires itself.

Transmit bytes are taken little-endian from two 32-bit words. Received bytes are stored in the same order in two receive words. When the transaction finishes, the launch bit clears and a cause bit is set. A status bit reports a NACK. A maskable interrupt follows the cause bits.

Top module: `i2c_xact_seq`

## Requirements
- R1: Control word at offset 0xD0 uses these fields: bit 0 write phase, bit 1 read phase, bits 11:2 target address, bit 12 ten-bit addressing, bits 15:13 write count minus one, bits 18:16 read count minus one, bit 19 go, bit 20 repeated START. A write with bit 19 set and bit 0 or bit 1 set launches a transaction; a write with bit 19 clear stores the word and issues no command.
- R2: Each address phase sends header byte {addr[6:0],dir} in 7-bit mode, or {5'b11110,addr[9:8],dir} followed by addr[7:0] in 10-bit mode, with dir=0 for the write phase and dir=1 for the read phase.
- R3: The write phase sends count bytes, byte 0 first from bits 7:0 of the word at 0xC0, continuing through 0xC4.
- R4: The read phase issues count READ commands, flagging only the last one to be answered with NACK, and stores byte i at bits 8i+7:8i of the 64-bit value formed by 0xCC:0xC8.
- R5: With both phases and bit 20 set, the command order is START, write address, data, RSTART, read address, reads, STOP. With bit 20 clear, a STOP and a START separate the two phases.
- R6: A NACK to any address or written byte makes the next command STOP, suppresses all further data, and sets bit 0 of the status word at 0xD4.
- R7: On completion, control bit 19 reads 0, bit 0 of the cause word at 0xD8 is set, and status bit 0 is 0 if no NACK occurred.
- R8: The irq output equals the OR of (cause AND mask at 0xDC), registered one cycle after the cause and mask registers.
- R9: Control writes during a transaction are ignored.
- R10: cmd_valid is a one-cycle pulse. No new command is issued until rsp_valid answers the previous one.
- R11: Writing zero to 0xD8 clears the cause bit, and this clears irq.
- R12: After reset all registers read zero and irq and cmd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe, data one cycle later |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Registered read data |
| cmd_valid | output | 1 | Command pulse to byte engine |
| cmd_op | output | 3 | 1 START, 2 RSTART, 3 WRITE, 4 READ, 5 STOP |
| cmd_data | output | 8 | Byte to write |
| cmd_last | output | 1 | Answer this read byte with NACK |
| rsp_valid | input | 1 | Engine finished the command |
| rsp_ack | input | 1 | Target acknowledged a written byte |
| rsp_data | input | 8 | Byte received by a READ |
| irq | output | 1 | Interrupt request |

## Verification
A wrong sequencer state shows first at the command port. A misplaced phase, a wrong header byte, a missing RSTART or a read that continues after a NACK is a wrong cmd_op or cmd_data on the next command pulse, only a few cycles after the fault. A wrong byte index shows in the receive words or in the order of the data commands. A lost completion shows as a cause bit or irq that never rises, or as a go bit that stays set. Every command is logged and compared with an expected list computed from the control word.

// File: rtl/i2c_xact_pkg.sv
package i2c_xact_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_START  = 3'd1,
    OP_RSTART = 3'd2,
    OP_WRITE  = 3'd3,
    OP_READ   = 3'd4,
    OP_STOP   = 3'd5
  } i2c_op_e;

  localparam int LEN_W = 3;

  localparam logic [7:0] OFF_TXLO  = 8'hC0;
  localparam logic [7:0] OFF_TXHI  = 8'hC4;
  localparam logic [7:0] OFF_RXLO  = 8'hC8;
  localparam logic [7:0] OFF_RXHI  = 8'hCC;
  localparam logic [7:0] OFF_CTRL  = 8'hD0;
  localparam logic [7:0] OFF_STAT  = 8'hD4;
  localparam logic [7:0] OFF_CAUSE = 8'hD8;
  localparam logic [7:0] OFF_MASK  = 8'hDC;
  localparam logic [7:0] OFF_TIME  = 8'hE0;

  localparam int CB_WR  = 0;
  localparam int CB_RD  = 1;
  localparam int CB_TEN = 12;
  localparam int CB_TXL = 13;
  localparam int CB_RXL = 16;
  localparam int CB_GO  = 19;
  localparam int CB_RS  = 20;
endpackage

// File: rtl/i2c_xact_fsm.sv
module i2c_xact_fsm
  import i2c_xact_pkg::*;
#(
  parameter int NBYTES = 8,
  localparam int TXW = NBYTES * 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             ten,
  input  logic             rs_en,
  input  logic [9:0]       taddr,
  input  logic [LEN_W-1:0] txl,
  input  logic [LEN_W-1:0] rxl,
  input  logic [TXW-1:0]   tx,
  output logic             cmd_valid,
  output i2c_op_e          cmd_op,
  output logic [7:0]       cmd_data,
  output logic             cmd_last,
  input  logic             rsp_valid,
  input  logic             rsp_ack,
  input  logic [7:0]       rsp_data,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             rx_we,
  output logic [LEN_W-1:0] rx_idx,
  output logic [7:0]       rx_byte
);
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_RSTART, S_HDR, S_LOADDR, S_WDATA, S_RDATA, S_STOP
  } st_e;

  st_e              st;
  logic             waiting, rd_phase, more_rd;
  logic [LEN_W-1:0] idx;
  logic [7:0]       hdr;

  assign hdr  = ten ? {5'b11110, taddr[9:8], rd_phase} : {taddr[6:0], rd_phase};
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; waiting <= 1'b0; rd_phase <= 1'b0; more_rd <= 1'b0;
      idx <= '0; err <= 1'b0; done <= 1'b0;
      cmd_valid <= 1'b0; cmd_op <= OP_NONE; cmd_data <= '0; cmd_last <= 1'b0;
      rx_we <= 1'b0; rx_idx <= '0; rx_byte <= '0;
    end else begin
      cmd_valid <= 1'b0;
      done      <= 1'b0;
      rx_we     <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          st       <= S_START;
          rd_phase <= !wr_en;
          more_rd  <= wr_en && rd_en && !rs_en;
          err      <= 1'b0;
        end
      end else if (!waiting) begin
        cmd_valid <= 1'b1;
        waiting   <= 1'b1;
        cmd_data  <= '0;
        cmd_last  <= 1'b0;
        case (st)
          S_START:  cmd_op <= OP_START;
          S_RSTART: cmd_op <= OP_RSTART;
          S_HDR:    begin cmd_op <= OP_WRITE; cmd_data <= hdr; end
          S_LOADDR: begin cmd_op <= OP_WRITE; cmd_data <= taddr[7:0]; end
          S_WDATA:  begin cmd_op <= OP_WRITE; cmd_data <= tx[{idx, 3'b000} +: 8]; end
          S_RDATA:  begin cmd_op <= OP_READ; cmd_last <= (idx == rxl); end
          default:  cmd_op <= OP_STOP;
        endcase
      end else if (rsp_valid) begin
        waiting <= 1'b0;
        case (st)
          S_START, S_RSTART: st <= S_HDR;
          S_HDR, S_LOADDR: begin
            idx <= '0;
            if (!rsp_ack) begin
              err <= 1'b1; st <= S_STOP;
            end else if (st == S_HDR && ten) st <= S_LOADDR;
            else st <= rd_phase ? S_RDATA : S_WDATA;
          end
          S_WDATA: begin
            if (!rsp_ack) begin
              err <= 1'b1; st <= S_STOP;
            end else if (idx == txl) begin
              if (rd_en && rs_en) begin
                rd_phase <= 1'b1; st <= S_RSTART;
              end else st <= S_STOP;
            end else idx <= idx + 1'b1;
          end
          S_RDATA: begin
            rx_we   <= 1'b1;
            rx_idx  <= idx;
            rx_byte <= rsp_data;
            if (idx == rxl) st <= S_STOP;
            else idx <= idx + 1'b1;
          end
          default: begin
            if (more_rd && !err) begin
              more_rd <= 1'b0; rd_phase <= 1'b1; st <= S_START;
            end else begin
              done <= 1'b1; st <= S_IDLE;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_xact_regs.sv
module i2c_xact_regs
  import i2c_xact_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 32,
  localparam int BUFW  = 2 * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             fsm_busy,
  input  logic             done,
  input  logic             done_err,
  input  logic             rx_we,
  input  logic [LEN_W-1:0] rx_idx,
  input  logic [7:0]       rx_byte,
  output logic [DW-1:0]    ctrl_q,
  output logic [BUFW-1:0]  tx_q,
  output logic             start_q,
  output logic [DW-1:0]    cause_q,
  output logic [DW-1:0]    mask_q,
  output logic             irq
);
  logic [BUFW-1:0] rx_q;
  logic [DW-1:0]   status_q, timing_q;
  logic            busy_any;

  assign busy_any = fsm_busy | start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0; rx_q <= '0; ctrl_q <= '0; status_q <= '0; cause_q <= '0;
      mask_q <= '0; timing_q <= '0; start_q <= 1'b0; irq <= 1'b0; reg_rdata <= '0;
    end else begin
      start_q <= 1'b0;
      if (reg_wr) begin
        if (reg_addr == ADDR_W'(OFF_TXLO)) tx_q[DW-1:0] <= reg_wdata;
        if (reg_addr == ADDR_W'(OFF_TXHI)) tx_q[BUFW-1:DW] <= reg_wdata;
        if (reg_addr == ADDR_W'(OFF_CAUSE)) cause_q <= reg_wdata;
        if (reg_addr == ADDR_W'(OFF_MASK)) mask_q <= reg_wdata;
        if (reg_addr == ADDR_W'(OFF_TIME)) timing_q <= reg_wdata;
        if (reg_addr == ADDR_W'(OFF_CTRL) && !busy_any) begin
          ctrl_q <= reg_wdata;
          if (reg_wdata[CB_GO] && (reg_wdata[CB_WR] || reg_wdata[CB_RD])) begin
            start_q  <= 1'b1;
            status_q <= '0;
          end
        end
      end
      if (rx_we) rx_q[{rx_idx, 3'b000} +: 8] <= rx_byte;
      if (done) begin
        ctrl_q[CB_GO] <= 1'b0;
        cause_q[0]    <= 1'b1;
        status_q[0]   <= done_err;
      end
      irq <= |(cause_q & mask_q);
      if (reg_rd) begin
        if (reg_addr == ADDR_W'(OFF_TXLO))       reg_rdata <= tx_q[DW-1:0];
        else if (reg_addr == ADDR_W'(OFF_TXHI))  reg_rdata <= tx_q[BUFW-1:DW];
        else if (reg_addr == ADDR_W'(OFF_RXLO))  reg_rdata <= rx_q[DW-1:0];
        else if (reg_addr == ADDR_W'(OFF_RXHI))  reg_rdata <= rx_q[BUFW-1:DW];
        else if (reg_addr == ADDR_W'(OFF_CTRL))  reg_rdata <= ctrl_q;
        else if (reg_addr == ADDR_W'(OFF_STAT))  reg_rdata <= status_q;
        else if (reg_addr == ADDR_W'(OFF_CAUSE)) reg_rdata <= cause_q;
        else if (reg_addr == ADDR_W'(OFF_MASK))  reg_rdata <= mask_q;
        else if (reg_addr == ADDR_W'(OFF_TIME))  reg_rdata <= timing_q;
        else reg_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq
  import i2c_xact_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 32,
  localparam int NBYTES = (2 * DW) / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [7:0]        cmd_data,
  output logic              cmd_last,
  input  logic              rsp_valid,
  input  logic              rsp_ack,
  input  logic [7:0]        rsp_data,
  output logic              irq
);
  logic [DW-1:0]     ctrl_q, cause_q, mask_q;
  logic [2*DW-1:0]   tx_q;
  logic              start_q, fsm_busy, done, done_err, rx_we;
  logic [LEN_W-1:0]  rx_idx;
  logic [7:0]        rx_byte;
  i2c_op_e           op_e;

  assign cmd_op = op_e;

  i2c_xact_regs #(.ADDR_W(ADDR_W), .DW(DW)) regs_i (
    .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .fsm_busy, .done, .done_err, .rx_we, .rx_idx, .rx_byte,
    .ctrl_q, .tx_q, .start_q, .cause_q, .mask_q, .irq
  );

  i2c_xact_fsm #(.NBYTES(NBYTES)) fsm_i (
    .clk, .rst, .start(start_q),
    .wr_en(ctrl_q[CB_WR]), .rd_en(ctrl_q[CB_RD]), .ten(ctrl_q[CB_TEN]),
    .rs_en(ctrl_q[CB_RS]), .taddr(ctrl_q[11:2]),
    .txl(ctrl_q[CB_TXL +: LEN_W]), .rxl(ctrl_q[CB_RXL +: LEN_W]), .tx(tx_q),
    .cmd_valid, .cmd_op(op_e), .cmd_data, .cmd_last,
    .rsp_valid, .rsp_ack, .rsp_data,
    .busy(fsm_busy), .done, .err(done_err), .rx_we, .rx_idx, .rx_byte
  );
endmodule

// File: rtl/i2c_xact_chk.sv
module i2c_xact_chk
  import i2c_xact_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic          rsp_valid,
  input logic          rsp_ack,
  input logic          irq,
  input logic          done,
  input logic [DW-1:0] cause_q,
  input logic [DW-1:0] mask_q
);
  logic outst, last_wr, nack_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      outst <= 1'b0; last_wr <= 1'b0; nack_pend <= 1'b0;
    end else begin
      if (cmd_valid) begin
        outst     <= 1'b1;
        last_wr   <= (cmd_op == OP_WRITE);
        nack_pend <= 1'b0;
      end else if (rsp_valid) begin
        outst <= 1'b0;
        if (last_wr && !rsp_ack) nack_pend <= 1'b1;
      end
    end
  end

  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !outst);
  assert_cmd_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  assert_nack_then_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && nack_pend) |-> (cmd_op == OP_STOP));
  assert_irq_set_R8: assert property (@(posedge clk) disable iff (rst)
    (|(cause_q & mask_q)) |=> irq);
  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !(|(cause_q & mask_q)) |=> !irq);
  assert_done_cause_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> cause_q[0]);
  assert_reset_quiet_R12: assert property (@(posedge clk)
    rst |=> (!cmd_valid && !irq));
endmodule

bind i2c_xact_seq i2c_xact_chk #(.DW(DW)) chk_i (
  .clk, .rst, .cmd_valid, .cmd_op, .rsp_valid, .rsp_ack, .irq,
  .done, .cause_q, .mask_q
);

// File: tb/i2c_xact_seq_tb.sv
module i2c_xact_seq_tb_top;
  import i2c_xact_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int LOGN = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_valid, cmd_last, irq;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_data;
  logic        rsp_valid = 1'b0, rsp_ack = 1'b0;
  logic [7:0]  rsp_data = '0;

  i2c_xact_seq dut_i (
    .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .cmd_valid, .cmd_op, .cmd_data, .cmd_last,
    .rsp_valid, .rsp_ack, .rsp_data, .irq
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // byte-engine and target model
  int         wtot = 0, rtot = 0, log_n = 0, cd = 0;
  int         nack_at = -1;
  logic [2:0] cur_op = '0;
  logic [2:0] log_op [LOGN];
  logic [7:0] log_dat [LOGN];
  logic       log_last [LOGN];

  function automatic logic [7:0] rb(int n);
    return 8'(n * 73 + 92);
  endfunction

  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (cmd_valid) begin
      if (log_n < LOGN) begin
        log_op[log_n] <= cmd_op; log_dat[log_n] <= cmd_data; log_last[log_n] <= cmd_last;
      end
      log_n  <= log_n + 1;
      cur_op <= cmd_op;
      cd     <= 3;
    end else if (cd > 0) begin
      cd <= cd - 1;
      if (cd == 1) begin
        rsp_valid <= 1'b1;
        rsp_ack   <= 1'b1;
        if (cur_op == OP_WRITE) begin
          rsp_ack <= (wtot != nack_at);
          wtot    <= wtot + 1;
        end else if (cur_op == OP_READ) begin
          rsp_data <= rb(rtot);
          rtot     <= rtot + 1;
        end
      end
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  // expected command list
  logic [2:0] e_op [64];
  logic [7:0] e_dat [64];
  logic       e_last [64];
  int         e_n;
  bit         e_err;

  task automatic push(logic [2:0] op, logic [7:0] d, logic l);
    e_op[e_n] = op; e_dat[e_n] = d; e_last[e_n] = l; e_n++;
  endtask

  task automatic pw(logic [7:0] d, int nk, inout int w, inout bit er);
    push(OP_WRITE, d, 1'b0);
    if (w == nk) er = 1;
    w++;
  endtask

  task automatic paddr(bit ten, logic [9:0] ad, bit dir, int nk, inout int w, inout bit er);
    pw(ten ? {5'b11110, ad[9:8], dir} : {ad[6:0], dir}, nk, w, er);
    if (ten && !er) pw(ad[7:0], nk, w, er);
  endtask

  task automatic build(bit wr, bit rd, bit ten, bit rs, logic [9:0] ad,
                       int txl, int rxl, logic [63:0] tx, int nk);
    int w = 0;
    bit er = 0;
    e_n = 0;
    push(OP_START, 8'h00, 1'b0);
    if (wr) begin
      paddr(ten, ad, 1'b0, nk, w, er);
      for (int i = 0; i < txl; i++) if (!er) pw(tx[i*8 +: 8], nk, w, er);
    end
    if (!er && rd) begin
      if (wr) begin
        if (rs) push(OP_RSTART, 8'h00, 1'b0);
        else begin push(OP_STOP, 8'h00, 1'b0); push(OP_START, 8'h00, 1'b0); end
      end
      paddr(ten, ad, 1'b1, nk, w, er);
      for (int i = 0; i < rxl; i++) if (!er) push(OP_READ, 8'h00, i == rxl - 1);
    end
    push(OP_STOP, 8'h00, 1'b0);
    e_err = er;
  endtask

  task automatic run(string tag, bit wr, bit rd, bit ten, bit rs, logic [9:0] ad,
                     int txl, int rxl, logic [63:0] tx, int nk, bit msk, bit poke);
    logic [31:0] d, word, lo, hi;
    int lb, rbase, mism, guard;
    logic [63:0] exp_rx, got_rx;
    wr_reg(OFF_TXLO, tx[31:0]);
    wr_reg(OFF_TXHI, tx[63:32]);
    wr_reg(OFF_MASK, {31'b0, msk});
    wr_reg(OFF_CAUSE, 32'h0);
    lb = log_n; rbase = rtot;
    nack_at = (nk < 0) ? -1 : wtot + nk;
    build(wr, rd, ten, rs, ad, txl, rxl, tx, nk);
    word = {11'b0, rs, 1'b1, 3'(rxl - 1), 3'(txl - 1), ten, ad, rd, wr};
    wr_reg(OFF_CTRL, word);
    if (poke) wr_reg(OFF_CTRL, 32'h001F_FFFF);
    guard = 0;
    d = 0;
    while (!d[0] && guard < 2000) begin rd_reg(OFF_CAUSE, d); guard++; end
    chk({tag, " R7 cause set"}, 64'(d[0]), 64'd1);
    chk({tag, " R8 irq"}, 64'(irq), 64'(msk));
    @(negedge clk);
    chk({tag, " R5 command count"}, 64'(log_n - lb), 64'(e_n));
    mism = 0;
    for (int i = 0; i < e_n && i < log_n - lb; i++) begin
      if (log_op[lb+i] !== e_op[i]) mism++;
      else if (e_op[i] == OP_WRITE && log_dat[lb+i] !== e_dat[i]) mism++;
      else if (e_op[i] == OP_READ && log_last[lb+i] !== e_last[i]) mism++;
    end
    chk({tag, " R2 R3 R5 command order"}, 64'(mism), 64'd0);
    rd_reg(OFF_STAT, d);
    chk({tag, " R6 status error"}, 64'(d[0]), 64'(e_err));
    rd_reg(OFF_CTRL, d);
    chk({tag, " R7 go cleared"}, 64'(d[CB_GO]), 64'd0);
    if (poke) chk({tag, " R9 ctrl kept"}, 64'(d[11:2]), 64'(ad));
    if (rd && !e_err) begin
      rd_reg(OFF_RXLO, lo);
      rd_reg(OFF_RXHI, hi);
      got_rx = {hi, lo};
      exp_rx = '0;
      for (int i = 0; i < rxl; i++) exp_rx[i*8 +: 8] = rb(rbase + i);
      for (int i = rxl; i < 8; i++) got_rx[i*8 +: 8] = 8'h00;
      chk({tag, " R4 receive data"}, got_rx, exp_rx);
    end
    wr_reg(OFF_CAUSE, 32'h0);
    wr_reg(OFF_CTRL, 32'h0);
    @(negedge clk);
    chk({tag, " R11 irq cleared"}, 64'(irq), 64'd0);
    nack_at = -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n0;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk("R12 irq after reset", 64'(irq), 64'd0);
    chk("R12 cmd_valid after reset", 64'(cmd_valid), 64'd0);
    rd_reg(OFF_CTRL, d);  chk("R12 ctrl reset", 64'(d), 64'd0);
    rd_reg(OFF_CAUSE, d); chk("R12 cause reset", 64'(d), 64'd0);
    rd_reg(OFF_RXHI, d);  chk("R12 rx reset", 64'(d), 64'd0);

    // R1 go clear: stored, nothing launched
    n0 = log_n;
    wr_reg(OFF_CTRL, 32'h0000_0145);
    repeat (20) @(negedge clk);
    chk("R1 no launch without go", 64'(log_n - n0), 64'd0);
    rd_reg(OFF_CTRL, d);  chk("R1 ctrl readback", 64'(d), 64'h145);
    wr_reg(OFF_CTRL, 32'h0);

    run("w1 7b",       1, 0, 0, 0, 10'h050, 1, 1, 64'h0000_0000_0000_00A5, -1, 1, 0);
    run("w8 10b",      1, 0, 1, 0, 10'h2C7, 8, 1, 64'h8877_6655_4433_2211, -1, 1, 0);
    run("r8 7b",       0, 1, 0, 0, 10'h03A, 1, 8, 64'h0, -1, 1, 0);
    run("r1 10b",      0, 1, 1, 0, 10'h1F0, 1, 1, 64'h0, -1, 1, 0);
    run("wr rs",       1, 1, 0, 1, 10'h068, 3, 5, 64'h0000_0000_00C3_B2A1, -1, 1, 0);
    run("wr no rs",    1, 1, 0, 0, 10'h011, 2, 2, 64'h0000_0000_0000_BEEF, -1, 1, 0);
    run("nack addr",   1, 1, 0, 1, 10'h022, 4, 4, 64'h1234_5678_9ABC_DEF0, 0, 1, 0);
    run("nack last w", 1, 0, 0, 0, 10'h033, 4, 1, 64'h0000_0000_CAFE_F00D, 4, 1, 0);
    run("nack rd hdr", 1, 1, 1, 1, 10'h3FF, 2, 3, 64'h0000_0000_0000_5A5A, 4, 1, 0);
    run("masked",      1, 1, 0, 1, 10'h044, 1, 2, 64'h0000_0000_0000_0077, -1, 0, 0);
    run("busy poke",   1, 0, 0, 0, 10'h055, 8, 1, 64'hF0E1_D2C3_B4A5_9687, -1, 1, 1);

    for (int k = 0; k < 30; k++) begin
      int mode, txl, rxl, nk, hc, tot;
      bit ten, rs, wr, rd;
      logic [9:0] ad;
      mode = int'($urandom % 3);
      wr = (mode != 1); rd = (mode != 0);
      ten = $urandom % 2; rs = $urandom % 2;
      ad = 10'($urandom);
      txl = 1 + int'($urandom % 8); rxl = 1 + int'($urandom % 8);
      hc = ten ? 2 : 1;
      tot = (wr ? hc + txl : 0) + (rd ? hc : 0);
      nk = ($urandom % 4 == 0) ? int'($urandom % tot) : -1;
      run("random", wr, rd, ten, rs, ad, txl, rxl, {$urandom, $urandom}, nk, 1, 0);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule